// File: doc/BRIEF.md
# Tiled View Address Generator

This block turns a pixel coordinate, seen through one of eight rotated or mirrored views of a tiled surface, into the 32-bit address a memory client issues to reach that pixel. A request carries a pixel-size code (8, 16 or 32 bits per pixel, plus a page-mode code that this block refuses), a 3-bit view code and an X/Y pair. One clock later the block returns the packed address, a flag saying whether the request was accepted or rejected, and the row stride that a client walking a line of the chosen view must add per row.

Inside, one datapath lane per tiled pixel size checks the coordinates against the field widths for that size and mirrors each axis by XOR with its full mask. It swaps the axes when the view is turned by 90 or 270 degrees, packs Y above X (or X above Y), and scales the result to the pixel size. The view code and the size code are placed in the top five address bits so that the memory side can decode them. The container field widths are parameters.

Top module: `tva_addr_gen`

## Requirements
- R1: A request sampled with `in_valid` high produces, exactly one clock later, either `out_valid` or `out_err` high (never both); with `in_valid` low the following cycle has both low.
- R2: On an accepted request `out_addr[31:29]` equals the view code and `out_addr[28:27]` equals the size code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit).
- R3: The size code selects shifts (sx, sy) of (0,0), (0,1) and (1,1); the X field has CW_BITS-sx bits and the Y field CH_BITS-sy bits, the packed offset is shifted left by sx+sy, so its low sx+sy bits are zero, and it stays within bits [26:0].
- R4: If X exceeds 2^(CW_BITS-sx)-1 or Y exceeds 2^(CH_BITS-sy)-1, the request is rejected: `out_err` high, `out_valid` low, address and stride 0.
- R5: Size code 3 (page mode) is always rejected with `out_err` high and address and stride 0.
- R6: View code bit 1 replaces X by X XOR its field mask and bit 0 replaces Y by Y XOR its field mask, before any swap.
- R7: With view code bit 2 clear the offset is (Y << xbits) + X; with it set it is (X << ybits) + Y, where X and Y are the mirrored coordinates.
- R8: The stride is 2^(CH_BITS+sx) when view code bit 2 is set and 2^(CW_BITS+sy) otherwise.
- R9: `out_addr` and `out_stride` keep their value in every cycle that follows a cycle with `in_valid` low.
- R10: During and right after reset `out_valid`, `out_err`, `out_addr` and `out_stride` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| in_fmt | input | 2 | Pixel-size code |
| in_orient | input | 3 | View code: bit 0 mirror Y, bit 1 mirror X, bit 2 swap axes |
| in_x | input | COORD_W | Pixel X in the view |
| in_y | input | COORD_W | Pixel Y in the view |
| out_valid | output | 1 | Accepted result this cycle |
| out_err | output | 1 | Rejected request this cycle |
| out_addr | output | 32 | Packed tiled address, 0 on rejection |
| out_stride | output | 32 | Row stride of the view, 0 on rejection |

## Verification
The embedded assertions watch on every cycle the one-cycle handshake, the exclusivity of accept and reject, the size and view fields of accepted addresses, pixel alignment of the offset, the zeroed outputs of a rejection, page-mode refusal and the holding of the outputs between requests. Whether an offset value is right (the mirror masks, the axis order, the stride chosen for a view, and the exact boundary where a coordinate becomes out of range) can only be shown by the bench, which drives every size and view code through boundary and random coordinates and compares each cycle against its own arithmetic model.

// File: rtl/tva_pkg.sv
package tva_pkg;

  // pixel-size codes carried in address bits [28:27]
  typedef enum logic [1:0] {
    PIX8   = 2'd0,
    PIX16  = 2'd1,
    PIX32  = 2'd2,
    PIXPG  = 2'd3
  } pix_fmt_e;

  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned OFF_FIELD  = 27;
  localparam int unsigned N_TILED    = 3;

  // per-size axis shifts
  function automatic int unsigned shift_x(input int unsigned fmt);
    return (fmt == 2) ? 1 : 0;
  endfunction

  function automatic int unsigned shift_y(input int unsigned fmt);
    return (fmt >= 1) ? 1 : 0;
  endfunction

  typedef struct packed {
    logic        ok;
    logic [31:0] addr;
    logic [31:0] stride;
  } tva_res_t;

endpackage

// File: rtl/tva_lane.sv
module tva_lane
  import tva_pkg::*;
#(
  parameter int unsigned FMT     = 0,
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13,
  parameter int unsigned COORD_W = 16
) (
  input  logic [COORD_W-1:0]       x,
  input  logic [COORD_W-1:0]       y,
  input  logic [2:0]               orient,
  output logic                     in_range,
  output logic [OFF_FIELD-1:0]     offset,
  output logic [31:0]              stride
);

  localparam int unsigned SX   = shift_x(FMT);
  localparam int unsigned SY   = shift_y(FMT);
  localparam int unsigned XB   = CW_BITS - SX;
  localparam int unsigned YB   = CH_BITS - SY;
  localparam int unsigned SH   = SX + SY;
  localparam int unsigned PK_W = XB + YB;
  localparam longint unsigned XMAX = (64'd1 << XB) - 64'd1;
  localparam longint unsigned YMAX = (64'd1 << YB) - 64'd1;

  logic [XB-1:0]   x_m;
  logic [YB-1:0]   y_m;
  logic [PK_W-1:0] packed_off;
  logic            x_ok, y_ok;

  // range check on the full coordinate width
  always_comb begin
    x_ok     = (64'(x) <= XMAX);
    y_ok     = (64'(y) <= YMAX);
    in_range = x_ok && y_ok;
  end

  // per-axis mirror by XOR with the full field mask
  always_comb begin
    x_m = x[XB-1:0] ^ (orient[1] ? {XB{1'b1}} : {XB{1'b0}});
    y_m = y[YB-1:0] ^ (orient[0] ? {YB{1'b1}} : {YB{1'b0}});
  end

  // axis swap and packing
  always_comb begin
    if (orient[2]) packed_off = {x_m, y_m};
    else           packed_off = {y_m, x_m};
  end

  // pixel-size scaling
  generate
    if (SH == 0) begin : g_noshift
      assign offset = OFF_FIELD'(packed_off);
    end else begin : g_shift
      assign offset = OFF_FIELD'({packed_off, {SH{1'b0}}});
    end
  endgenerate

  // row stride of the view
  always_comb begin
    if (orient[2]) stride = 32'd1 << (CH_BITS + SX);
    else           stride = 32'd1 << (CW_BITS + SY);
  end

endmodule

// File: rtl/tva_out_reg.sv
module tva_out_reg
  import tva_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  tva_res_t    res,
  output logic        out_valid,
  output logic        out_err,
  output logic [31:0] out_addr,
  output logic [31:0] out_stride
);

  logic        valid_d, err_d;
  logic [31:0] addr_d, stride_d;

  // next-state
  always_comb begin
    valid_d  = en &&  res.ok;
    err_d    = en && !res.ok;
    addr_d   = out_addr;
    stride_d = out_stride;
    if (en) begin
      addr_d   = res.ok ? res.addr   : 32'd0;
      stride_d = res.ok ? res.stride : 32'd0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_addr   <= 32'd0;
      out_stride <= 32'd0;
    end else begin
      out_valid  <= valid_d;
      out_err    <= err_d;
      out_addr   <= addr_d;
      out_stride <= stride_d;
    end
  end

  AST_ACCEPT_REJECT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err)); // R1

  AST_REJECT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_addr == 32'd0 && out_stride == 32'd0)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(out_addr) && $stable(out_stride))); // R9

endmodule

// File: rtl/tva_addr_gen.sv
module tva_addr_gen
  import tva_pkg::*;
#(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13,
  parameter int unsigned COORD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         in_fmt,
  input  logic [2:0]         in_orient,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               out_valid,
  output logic               out_err,
  output logic [31:0]        out_addr,
  output logic [31:0]        out_stride
);

  logic [1:0] rst_sync;
  logic       rst_q_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic                 lane_ok     [N_TILED];
  logic [OFF_FIELD-1:0] lane_off    [N_TILED];
  logic [31:0]          lane_stride [N_TILED];

  for (genvar f = 0; f < N_TILED; f++) begin : g_lane
    tva_lane #(
      .FMT     (f),
      .CW_BITS (CW_BITS),
      .CH_BITS (CH_BITS),
      .COORD_W (COORD_W)
    ) lane_i (
      .x        (in_x),
      .y        (in_y),
      .orient   (in_orient),
      .in_range (lane_ok[f]),
      .offset   (lane_off[f]),
      .stride   (lane_stride[f])
    );
  end

  tva_res_t res;

  always_comb begin
    res = '0;
    if (in_fmt != PIXPG) begin
      res.ok     = lane_ok[in_fmt];
      res.addr   = {in_orient, in_fmt, lane_off[in_fmt]};
      res.stride = lane_stride[in_fmt];
    end
  end

  tva_out_reg oreg_i (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .en         (in_valid),
    .res        (res),
    .out_valid  (out_valid),
    .out_err    (out_err),
    .out_addr   (out_addr),
    .out_stride (out_stride)
  );

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> (out_valid || out_err)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> (!out_valid && !out_err)); // R1

  AST_FIELDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> (!out_valid ||
      (out_addr[31:29] == $past(in_orient) && out_addr[28:27] == $past(in_fmt)))); // R2

  AST_PIX_ALIGN: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> !((out_addr[28:27] != 2'd0) && out_addr[0])
               && !((out_addr[28:27] == 2'd2) && out_addr[1])); // R3

  AST_PAGE_REFUSED: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_fmt == 2'd3) |=> (out_err && out_addr == 32'd0)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_q_n |-> (!out_valid && !out_err && out_addr == 32'd0)); // R10

endmodule

// File: tb/tva_addr_gen_tb.sv
module tva_addr_gen_tb_top;

  localparam int CWB = 14;
  localparam int CHB = 13;
  localparam int CRW = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [1:0]     in_fmt;
  logic [2:0]     in_orient;
  logic [CRW-1:0] in_x, in_y;
  logic           out_valid, out_err;
  logic [31:0]    out_addr, out_stride;

  always #10 clk = ~clk; // 50 MHz

  tva_addr_gen #(.CW_BITS(CWB), .CH_BITS(CHB), .COORD_W(CRW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_err(out_err),
    .out_addr(out_addr), .out_stride(out_stride));

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  string tag      = "R10";

  // expected outputs for the cycle after the current drive
  bit          e_valid, e_err;
  longint      e_addr, e_stride;

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string t, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", t, what, act, exp);
    end
  endtask

  // behavioural model of one request
  task automatic model(input int fmt, input int ori, input longint x, input longint y);
    longint sx, sy, xb, yb, xm, ym, xx, yy, off;
    bit ok;
    sx = (fmt == 2) ? 1 : 0;
    sy = (fmt == 1 || fmt == 2) ? 1 : 0;
    xb = CWB - sx;  yb = CHB - sy;
    xm = (64'd1 << xb) - 1;  ym = (64'd1 << yb) - 1;
    ok = (fmt != 3) && (x <= xm) && (y <= ym);
    e_valid = ok;
    e_err   = !ok;
    if (!ok) begin
      e_addr = 0; e_stride = 0;
    end else begin
      xx = ((ori & 2) != 0) ? (xm - x) : x;   // XOR with all-ones mask
      yy = ((ori & 1) != 0) ? (ym - y) : y;
      off = ((ori & 4) != 0) ? (xx * (64'd1 << yb) + yy) : (yy * (64'd1 << xb) + xx);
      off = off * (64'd1 << (sx + sy));
      e_addr   = (longint'(ori) << 29) + (longint'(fmt) << 27) + (off % (64'd1 << 27));
      e_stride = ((ori & 4) != 0) ? (64'd1 << (CHB + sx)) : (64'd1 << (CWB + sy));
    end
  endtask

  // wait one clock and compare at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "out_valid",  longint'(out_valid),  longint'(e_valid));
    chk(tag, "out_err",    longint'(out_err),    longint'(e_err));
    chk(tag, "out_addr",   longint'(out_addr),   e_addr);
    chk(tag, "out_stride", longint'(out_stride), e_stride);
  endtask

  task automatic req(input string t, input int fmt, input int ori, input longint x, input longint y);
    tag       = t;
    in_valid  = 1'b1;
    in_fmt    = 2'(fmt);
    in_orient = 3'(ori);
    in_x      = CRW'(x);
    in_y      = CRW'(y);
    model(fmt, ori, x, y);
    step();
  endtask

  task automatic idle(input string t);
    tag      = t;
    in_valid = 1'b0;
    in_x     = CRW'($urandom);
    in_fmt   = 2'($urandom);
    e_valid  = 1'b0;
    e_err    = 1'b0;   // address and stride expected to hold
    step();
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_fmt = '0; in_orient = '0; in_x = '0; in_y = '0;
    e_valid = 0; e_err = 0; e_addr = 0; e_stride = 0;
    repeat (3) @(negedge clk);
    tag = "R10";
    chk("R10", "reset out_valid", longint'(out_valid), 0);
    chk("R10", "reset out_addr",  longint'(out_addr), 0);
    rst_n = 1'b1;
    repeat (3) step();

    // hand-computed values: 8-bit, upright view, x=5 y=3
    req("R7", 0, 0, 5, 3);
    chk("R7", "literal addr", longint'(out_addr), 64'h0000_C005);
    // 32-bit, swap only: (5<<12)+3 shifted by 2, fields 4 and 2
    req("R2", 2, 4, 5, 3);
    chk("R2", "literal addr", longint'(out_addr), 64'h9001_4000 + 64'd12);
    chk("R8", "literal stride", longint'(out_stride), 64'd1 << 14);
    // 16-bit, mirror X: x 0 -> 0x3FFF, y 1, shift 1
    req("R6", 1, 2, 0, 1);
    chk("R6", "literal addr", longint'(out_addr), 64'h4800_0000 + ((64'd1 << 14) + 64'h3FFF) * 2);

    // every size and view
    for (int f = 0; f < 3; f++)
      for (int o = 0; o < 8; o++) begin
        req("R6", f, o, 37 + o, 11 + f);
        req("R8", f, o, 0, 0);
        req("R3", f, o, (64'd1 << (CWB - ((f == 2) ? 1 : 0))) - 1,
                         (64'd1 << (CHB - ((f >= 1) ? 1 : 0))) - 1);
      end

    // range boundaries
    for (int f = 0; f < 3; f++) begin
      longint xm, ym;
      xm = (64'd1 << (CWB - ((f == 2) ? 1 : 0))) - 1;
      ym = (64'd1 << (CHB - ((f >= 1) ? 1 : 0))) - 1;
      req("R4", f, 0, xm + 1, 0);
      req("R4", f, 5, 0, ym + 1);
      req("R4", f, 3, xm, ym);
      req("R4", f, 7, 65535, 65535);
    end

    // page mode refused
    for (int o = 0; o < 8; o++) req("R5", 3, o, o, 1);

    // back-to-back then idle hold
    req("R1", 1, 6, 100, 200);
    req("R1", 2, 1, 300, 10);
    idle("R9");
    idle("R9");
    req("R1", 0, 5, 9000, 8000);
    idle("R1");

    // random traffic
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 4) == 0) idle("R9");
      else req("R7", int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
               longint'($urandom_range(0, 17000)), longint'($urandom_range(0, 8500)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule